// File: doc/BRIEF.md
# Prioritized Interrupt Event Controller

This block gathers 128 level-sensitive interrupt request lines. It presents the event code and priority level of the source that should be serviced next. Every request line maps to a slot. The slot's event code is its index times 0x20, so all codes stay below 0x1000. Each slot has a 4-bit priority and a pending bit that follows the request line.

Priorities come from three places:
- The fifteen external request lines have fixed, descending values.
- Three timer slots take their priorities from nibbles of a 16-bit priority register.
- Four serial-port slots share one nibble of a 32-bit priority word.

All other slots have priority zero and count as unimplemented. A small register file holds the priority and mask registers, each with a defined reset value. A write port updates them and a combinational read port returns them.

A newly raised request takes over the output only if its priority is strictly above the level currently shown. Two events trigger a full rescan, which picks the highest priority and breaks ties by the lowest index:
- a request dropping;
- any register write.

Outputs are registered, so every change appears one clock after the input that caused it.

Top module: `irq_event_ctrl`

## Requirements
- R1: The event code is the selected slot index times 0x20 (12 bits, slots 0..127). When no slot with nonzero priority is pending, code, level and `irq_valid` are all zero.
- R2: External request k (k = 0..14) sits in slot 16+k (code 0x200 + k·0x20) and has the fixed priority 15−k.
- R3: Timer slots 32, 33 and 34 take their priority from bits 15:12, 11:8 and 7:4 of register 0 (a 16-bit register).
- R4: Serial slots 56..59 (codes 0x700..0x760) all use bits 19:16 of register 6 as their priority.
- R5: A newly raised request replaces the current selection only if nothing is selected or its priority is strictly greater than the current level. Equal priority keeps the current selection.
- R6: When any request drops, the block rescans all pending slots. It selects the strictly highest priority and, on a tie, the lowest index.
- R7: Raising a request on a zero-priority slot pulses `irq_err` high for one cycle and never selects that slot.
- R8: Register index map and reset values:
  - 0..3: 16-bit registers; register 3 resets to 0xDA74, the others to 0.
  - 4..7: 32-bit priority words, each resetting to 0x33333333.
  - 8: mask, resets to 0xF3FF7FFF.
  - 9: mask, resets to 0x00FFFFFF.

  Writes to 16-bit registers keep only bits 15:0. Writes to indices 10..15 are ignored, and those indices read as zero.
- R9: A register write triggers a full rescan that uses the newly written priorities, visible on the next cycle. Pending bits are unaffected by the write.
- R10: Outputs are registered and reflect the request and write inputs sampled at the previous rising clock edge. `irq_valid` is high exactly when the level is nonzero, and a valid selection always names a slot whose request was high at that edge.
- R11: When several requests rise together, the candidate is the highest-priority one among them, lowest index on a tie, and is then judged as in R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 128 | Level request per slot |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register index for writes |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Register index for reads |
| rd_data | output | 32 | Read data (combinational) |
| irq_code | output | 12 | Event code of the selected slot |
| irq_level | output | 4 | Priority of the selected slot |
| irq_valid | output | 1 | Level is nonzero |
| irq_err | output | 1 | Zero-priority request seen (one-cycle pulse) |

## Verification
The assertions check four properties on every cycle:
- an idle output carries a zero code;
- a valid selection names a slot whose request was high;
- a zero-priority pulse follows some active request;
- the level never drops across a cycle with no falling request and no write.

Only the bench scenarios can show the finer points of selection: the tie rules that differ between the raise path and the rescan path, the mapping of priority nibbles to slots, that a write preserves pending sources, and the reset and truncation behaviour of the register file.

// File: rtl/irq_event_pkg.sv
package irq_event_pkg;
    localparam int N_SLOTS   = 128;
    localparam int PRIO_W    = 4;
    localparam int IDX_W     = $clog2(N_SLOTS);
    localparam int CODE_SHIFT = 5;
    localparam int CODE_W    = IDX_W + CODE_SHIFT;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 4;
    localparam int N_REGS    = 10;

    localparam int REG_TMR_PRI = 0;
    localparam int REG_SER_PRI = 6;
    localparam int N_SHORT     = 4;
    localparam int TMR_COUNT   = 3;
    localparam int TMR_TOP_BIT = 15;
    localparam int SER_LSB     = 16;

    function automatic logic [DATA_W-1:0] reg_reset(input int idx);
        case (idx)
            3:          return 32'h0000_DA74;
            4, 5, 6, 7: return 32'h3333_3333;
            8:          return 32'hF3FF_7FFF;
            9:          return 32'h00FF_FFFF;
            default:    return '0;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] reg_keep(input int idx);
        return (idx < N_SHORT) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
    endfunction

    typedef struct packed {
        logic [N_SLOTS-1:0] pend;
        logic [IDX_W-1:0]   sel_idx;
        logic [PRIO_W-1:0]  lvl;
        logic               err;
    } sel_state_t;
endpackage

// File: rtl/irq_regfile.sv
module irq_regfile
    import irq_event_pkg::*;
#(
    parameter int NR = N_REGS,
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int PW = PRIO_W,
    parameter int TC = TMR_COUNT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [DW-1:0]    rd_data,
    output logic [TC*PW-1:0] tmr_field_d,
    output logic [PW-1:0]    ser_field_d
);
    logic [DW-1:0] regs_d [NR];
    logic [DW-1:0] regs_q [NR];

    always_comb begin
        for (int i = 0; i < NR; i++) begin
            regs_d[i] = regs_q[i];
            if (wr_en && wr_addr == AW'(i))
                regs_d[i] = wr_data & reg_keep(i);
        end
        rd_data = '0;
        for (int i = 0; i < NR; i++)
            if (rd_addr == AW'(i))
                rd_data = regs_q[i];
    end

    assign tmr_field_d = regs_d[REG_TMR_PRI][TMR_TOP_BIT -: TC*PW];
    assign ser_field_d = regs_d[REG_SER_PRI][SER_LSB +: PW];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NR; i++) regs_q[i] <= reg_reset(i);
        end else begin
            for (int i = 0; i < NR; i++) regs_q[i] <= regs_d[i];
        end
    end
endmodule

// File: rtl/irq_prio_map.sv
module irq_prio_map
    import irq_event_pkg::*;
#(
    parameter int NS        = N_SLOTS,
    parameter int PW        = PRIO_W,
    parameter int EXT_BASE  = 16,
    parameter int EXT_COUNT = 15,
    parameter int TMR_BASE  = 32,
    parameter int TC        = TMR_COUNT,
    parameter int SER_BASE  = 56,
    parameter int SER_COUNT = 4
) (
    input  logic [TC*PW-1:0] tmr_field,
    input  logic [PW-1:0]    ser_field,
    output logic [NS*PW-1:0] prio_flat
);
    localparam int MAXP = (1 << PW) - 1;

    for (genvar s = 0; s < NS; s++) begin : g_slot
        if (s >= EXT_BASE && s < EXT_BASE + EXT_COUNT) begin : g_ext
            assign prio_flat[s*PW +: PW] = PW'(MAXP - (s - EXT_BASE));
        end else if (s >= TMR_BASE && s < TMR_BASE + TC) begin : g_tmr
            assign prio_flat[s*PW +: PW] = tmr_field[(TC-1-(s-TMR_BASE))*PW +: PW];
        end else if (s >= SER_BASE && s < SER_BASE + SER_COUNT) begin : g_ser
            assign prio_flat[s*PW +: PW] = ser_field;
        end else begin : g_none
            assign prio_flat[s*PW +: PW] = '0;
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_event_pkg::*;
#(
    parameter int NS = N_SLOTS,
    parameter int PW = PRIO_W,
    parameter int IW = IDX_W
) (
    input  logic [NS-1:0]    cand,
    input  logic [NS*PW-1:0] prio_flat,
    output logic [IW-1:0]    win_idx,
    output logic [PW-1:0]    win_prio
);
    // Strict compare while walking upward: lowest index keeps a tie,
    // and a zero priority can never win.
    always_comb begin
        win_idx  = '0;
        win_prio = '0;
        for (int i = 0; i < NS; i++) begin
            if (cand[i] && prio_flat[i*PW +: PW] > win_prio) begin
                win_idx  = IW'(i);
                win_prio = prio_flat[i*PW +: PW];
            end
        end
    end
endmodule

// File: rtl/irq_event_ctrl.sv
module irq_event_ctrl
    import irq_event_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_SLOTS-1:0]   req,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [DATA_W-1:0]    rd_data,
    output logic [CODE_W-1:0]    irq_code,
    output logic [PRIO_W-1:0]    irq_level,
    output logic                 irq_valid,
    output logic                 irq_err
);
    sel_state_t st_d, st_q;

    logic [TMR_COUNT*PRIO_W-1:0] tmr_field_d;
    logic [PRIO_W-1:0]           ser_field_d;
    logic [N_SLOTS*PRIO_W-1:0]   prio_flat;
    logic [N_SLOTS-1:0]          rise, fall, prio_zero;
    logic [IDX_W-1:0]            scan_idx, new_idx;
    logic [PRIO_W-1:0]           scan_prio, new_prio;

    irq_regfile u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .tmr_field_d (tmr_field_d),
        .ser_field_d (ser_field_d)
    );

    irq_prio_map u_map (
        .tmr_field (tmr_field_d),
        .ser_field (ser_field_d),
        .prio_flat (prio_flat)
    );

    assign rise = req & ~st_q.pend;
    assign fall = st_q.pend & ~req;

    // Full rescan over the next pending set.
    irq_arbiter u_scan (
        .cand      (req),
        .prio_flat (prio_flat),
        .win_idx   (scan_idx),
        .win_prio  (scan_prio)
    );

    // Best of the sources that rose this cycle.
    irq_arbiter u_new (
        .cand      (rise),
        .prio_flat (prio_flat),
        .win_idx   (new_idx),
        .win_prio  (new_prio)
    );

    always_comb begin
        for (int i = 0; i < N_SLOTS; i++)
            prio_zero[i] = (prio_flat[i*PRIO_W +: PRIO_W] == '0);

        st_d      = st_q;
        st_d.pend = req;
        st_d.err  = |(rise & prio_zero);
        if ((|fall) || wr_en) begin
            st_d.sel_idx = scan_idx;
            st_d.lvl     = scan_prio;
        end else if (new_prio != '0 && (st_q.lvl == '0 || new_prio > st_q.lvl)) begin
            st_d.sel_idx = new_idx;
            st_d.lvl     = new_prio;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_code  = {st_q.sel_idx, {CODE_SHIFT{1'b0}}};
    assign irq_level = st_q.lvl;
    assign irq_valid = (st_q.lvl != '0);
    assign irq_err   = st_q.err;

    // R1: idle output carries a zero code
    a_r1_idle_code_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_valid |-> irq_code == '0);

    // R5: with no drop and no write, the level cannot fall
    a_r5_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && !(|fall) && !wr_en) |=> irq_level >= $past(irq_level));

    // R7: an error pulse follows some active request
    a_r7_err_has_req: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err |-> (|$past(req)));

    // R10: a valid selection names a slot that was requesting
    a_r10_sel_requested: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (|(($past(req) >> st_q.sel_idx) & N_SLOTS'(1))));
endmodule

// File: tb/sim_irq_event_ctrl.sv
module sim_irq_event_ctrl;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] req = '0;
    logic         wr_en = 1'b0;
    logic [3:0]   wr_addr = '0;
    logic [31:0]  wr_data = '0;
    logic [3:0]   rd_addr = '0;
    logic [31:0]  rd_data;
    logic [11:0]  irq_code;
    logic [3:0]   irq_level;
    logic         irq_valid;
    logic         irq_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [11:0] code;
        logic [3:0]  lvl;
        logic        err;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    irq_event_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq_code(irq_code), .irq_level(irq_level), .irq_valid(irq_valid),
        .irq_err(irq_err)
    );

    function automatic logic [127:0] sl(input int n);
        return 128'(1) << n;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [127:0] r, input bit we, input logic [3:0] wa,
                        input logic [31:0] wd, input logic [11:0] ec,
                        input logic [3:0] el, input bit ee, input string tag);
        exp_t e;
        @(negedge clk);
        req = r; wr_en = we; wr_addr = wa; wr_data = wd;
        e.code = ec; e.lvl = el; e.err = ee; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        rd_addr = a;
        #1;
        chk(rd_data == exp, tag, rd_data, exp);
    endtask

    // Monitor: pops one expectation per clock, sampled after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                chk(irq_code == e.code, {e.tag, " code"}, 32'(irq_code), 32'(e.code));
                chk(irq_level == e.lvl, {e.tag, " level"}, 32'(irq_level), 32'(e.lvl));
                chk(irq_valid == (e.lvl != 0), {e.tag, " valid R10"}, 32'(irq_valid), 32'(e.lvl != 0));
                chk(irq_err == e.err, {e.tag, " err"}, 32'(irq_err), 32'(e.err));
            end
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(irq_code == 0 && irq_level == 0 && !irq_valid && !irq_err,
            "R1 reset outputs", {irq_code, irq_level, irq_valid, irq_err}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        rd_chk(4'd3, 32'h0000DA74, "R8 reset reg3");
        rd_chk(4'd8, 32'hF3FF7FFF, "R8 reset reg8");
        rd_chk(4'd9, 32'h00FFFFFF, "R8 reset reg9");
        rd_chk(4'd4, 32'h33333333, "R8 reset reg4");
        rd_chk(4'd7, 32'h33333333, "R8 reset reg7");
        rd_chk(4'd0, 32'h0, "R8 reset reg0");

        step(sl(57), 0, 0, 0, 12'h720, 4'd3, 0, "R4 serial slot 57");
        step(sl(56)|sl(57), 0, 0, 0, 12'h720, 4'd3, 0, "R5 equal keeps");
        step(sl(30)|sl(56)|sl(57), 0, 0, 0, 12'h720, 4'd3, 0, "R5 lower keeps");
        step(sl(19)|sl(30)|sl(56)|sl(57), 0, 0, 0, 12'h260, 4'd12, 0, "R2 R5 higher wins");
        step(sl(30)|sl(56)|sl(57), 0, 0, 0, 12'h700, 4'd3, 0, "R6 rescan tie lowest");
        step(sl(30)|sl(56)|sl(57), 1, 4'd0, 32'hFFFF5000, 12'h700, 4'd3, 0, "R9 write no change");
        step(sl(30)|sl(32)|sl(56)|sl(57), 0, 0, 0, 12'h400, 4'd5, 0, "R3 timer0 prio");
        step(sl(30)|sl(32)|sl(56)|sl(57), 1, 4'd6, 32'h33393333, 12'h700, 4'd9, 0, "R4 R9 serial reprio");
        step(sl(30)|sl(32)|sl(56)|sl(57), 1, 4'd0, 32'h0000F000, 12'h400, 4'd15, 0, "R9 pending kept");
        step(sl(30)|sl(32)|sl(33)|sl(56)|sl(57), 0, 0, 0, 12'h400, 4'd15, 1, "R7 zero prio err");
        step(sl(30)|sl(32)|sl(33)|sl(56)|sl(57), 0, 0, 0, 12'h400, 4'd15, 0, "R7 err pulse ends");
        step('0, 0, 0, 0, 12'h000, 4'd0, 0, "R1 idle zero");
        step(sl(18)|sl(20), 0, 0, 0, 12'h240, 4'd13, 0, "R11 joint rise");
        step(sl(16)|sl(18)|sl(20), 0, 0, 0, 12'h200, 4'd15, 0, "R2 ext0 top");
        step(sl(16)|sl(18)|sl(20)|sl(127), 0, 0, 0, 12'h200, 4'd15, 1, "R7 slot127 err");
        step(sl(16)|sl(18)|sl(20)|sl(127), 1, 4'd12, 32'hFFFFFFFF, 12'h200, 4'd15, 0, "R8 bad index write");
        step(sl(18)|sl(20)|sl(127), 0, 0, 0, 12'h240, 4'd13, 0, "R6 drop rescan");
        step(sl(20)|sl(127), 0, 0, 0, 12'h280, 4'd11, 0, "R6 drop to last");
        step('0, 0, 0, 0, 12'h000, 4'd0, 0, "R1 all dropped");
        @(negedge clk);
        wr_en = 1'b0;
        repeat (2) @(posedge clk);
        rd_chk(4'd0, 32'h0000F000, "R8 short reg truncated");
        rd_chk(4'd6, 32'h33393333, "R8 word written");
        rd_chk(4'd12, 32'h0, "R8 bad index reads zero");
        rd_chk(4'd3, 32'h0000DA74, "R8 reg3 kept");
        chk(sb.size() == 0, "R10 scoreboard drained", sb.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule